// File: doc/BRIEF.md
# Eight-Operation ALU with Compare Flags

This block is an 8-bit arithmetic/logic unit. Its result path is purely combinational. A 3-bit select chooses one of eight operations on the two operands. The result appears in the same cycle that the inputs are applied.

Alongside the result, the unit derives the seven condition signals a branch unit tests:

- carry
- shift underflow
- shift overflow
- equal
- A above B
- B above A
- not equal

These conditions are copied into a flag register on a rising clock edge when the capture strobe is high. The register then holds them until the next capture, so a later jump can test the outcome of the most recent ALU instruction.

Increment shares the adder with add and subtract. It sets the carry-in and feeds a zero addend, so operand B plays no part in it. The compare flags are unsigned and are derived on every operation, whatever the select.

Top module: `alu8_flags`

## Requirements
- R1: Select 000 is ADD: result = (A + B) mod 256, and carry is the ninth bit of the sum.
- R2: Select 001 is SUB: result = (A - B) mod 256, and carry is 1 exactly when no borrow occurs (A >= B).
- R3: Select 011 is INC: result = (A + 1) mod 256 and carry is 1 only when A = 8'hFF; the value of B has no effect on the result or any flag other than the compare flags.
- R4: Select 010 is SHR: result = A shifted right by one with bit 7 = 0, and shift underflow equals A bit 0.
- R5: Shift overflow is 1 only for SHR when the result is zero while A was nonzero (A = 1). Every operation other than SHR gives shift underflow = 0 and shift overflow = 0.
- R6: Selects 100 XOR, 101 XNOR, 110 AND and 111 OR give the bitwise result, and carry = 0.
- R7: The compare flags treat A and B as unsigned and do not depend on the select. Exactly one of equal, A-above and B-above is 1, and not-equal is the inverse of equal.
- R8: Reset (rst_n low) clears all seven flags to 0. The flags load on a rising clock edge with flag_cap high and hold their value on every edge with flag_cap low.
- R9: The result is combinational: it follows A, B and the select within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| op_sel | input | 3 | Operation select |
| flag_cap | input | 1 | Capture strobe for the flag register |
| result | output | 8 | Combinational result |
| cy_q | output | 1 | Captured carry / no-borrow |
| shu_q | output | 1 | Captured shift underflow |
| sho_q | output | 1 | Captured shift overflow |
| eq_q | output | 1 | Captured A equal B |
| agt_q | output | 1 | Captured A above B |
| bgt_q | output | 1 | Captured B above A |
| ne_q | output | 1 | Captured A not equal B |

## Verification
The assertions check, on every cycle, the rules that hold for any operand values:

- flags hold steady while flag_cap is low;
- after every capture, exactly one compare flag is set and not-equal mirrors equal;
- shift flags are cleared after any non-shift capture;
- carry is cleared after any logic capture;
- increment carries only from 8'hFF;
- the shifted result always has a clear top bit.

Exact arithmetic values, borrow polarity, the A = 1 shift overflow, the wrap at 8'hFF, and increment ignoring B are shown only by the bench. It compares the result and the captured flags against its own model, over directed corner operands and seeded random traffic.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       op_sel,
  input  logic             flag_cap,
  output logic [WIDTH-1:0] result,
  output logic             cy_q,
  output logic             shu_q,
  output logic             sho_q,
  output logic             eq_q,
  output logic             agt_q,
  output logic             bgt_q,
  output logic             ne_q
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_SHR = 3'd2, OP_INC = 3'd3,
                         OP_XOR = 3'd4, OP_XNR = 3'd5, OP_AND = 3'd6, OP_OR  = 3'd7;

  logic             is_sub, is_inc, is_arith, is_shr;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;
  logic [6:0]       flags_n, flags_q;

  assign is_sub   = (op_sel == OP_SUB);
  assign is_inc   = (op_sel == OP_INC);
  assign is_shr   = (op_sel == OP_SHR);
  assign is_arith = (op_sel == OP_ADD) || is_sub || is_inc;

  assign addend = is_inc ? '0 : (is_sub ? ~b_in : b_in);
  assign sum    = {1'b0, a_in} + {1'b0, addend} + {{WIDTH{1'b0}}, (is_sub || is_inc)};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB, OP_INC: result = sum[WIDTH-1:0];
      OP_SHR:                 result = {1'b0, a_in[WIDTH-1:1]};
      OP_XOR:                 result = a_in ^ b_in;
      OP_XNR:                 result = ~(a_in ^ b_in);
      OP_AND:                 result = a_in & b_in;
      default:                result = a_in | b_in;
    endcase
  end

  assign flags_n = {
    is_arith & sum[WIDTH],
    is_shr & a_in[0],
    is_shr & (result == '0) & (a_in != '0),
    a_in == b_in,
    a_in > b_in,
    b_in > a_in,
    a_in != b_in
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flag_cap) flags_q <= flags_n;
  end

  assign {cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q} = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [2:0]       op_sel,
  input logic             flag_cap,
  input logic [WIDTH-1:0] result,
  input logic             cy_q,
  input logic             shu_q,
  input logic             sho_q,
  input logic             eq_q,
  input logic             agt_q,
  input logic             bgt_q,
  input logic             ne_q
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_cap |=> $stable({cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q}));

  p_cmp_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cap |=> ($countones({eq_q, agt_q, bgt_q}) == 1) && (ne_q != eq_q));

  p_shift_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cap && op_sel != 3'd2) |=> (!shu_q && !sho_q));

  p_logic_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cap && op_sel[2]) |=> !cy_q);

  p_inc_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cap && op_sel == 3'd3) |=> (cy_q == ($past(a_in) == '1)));

  always_comb begin
    if (rst_n && op_sel == 3'd2) p_shr_msb_r4: assert (result[WIDTH-1] == 1'b0);
  end
endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/1ps
module alu8_flags_bench;
  logic       clk = 0, rst_n = 0, flag_cap = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic [2:0] op_sel = 0;
  logic [7:0] result;
  logic       cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  alu8_flags u_alu8_flags (.*);

  function automatic logic [7:0] exp_res(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a / 2;
      3'd3: return a + 8'd1;
      3'd4: return a ^ b;
      3'd5: return ~(a ^ b);
      3'd6: return a & b;
      default: return a | b;
    endcase
  endfunction

  // {carry, underflow, overflow, eq, a>b, b>a, ne}
  function automatic logic [6:0] exp_flags(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
    int unsigned ia = a, ib = b;
    logic c = 0, u = 0, o = 0;
    case (op)
      3'd0: c = (ia + ib) > 255;
      3'd1: c = ia >= ib;
      3'd2: begin u = a[0]; o = (ia == 1); end
      3'd3: c = (ia == 255);
      default: c = 0;
    endcase
    return {c, u, o, ia == ib, ia > ib, ib > ia, ia != ib};
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4/R5";
      3'd3: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
    logic [6:0] ef;
    ef = exp_flags(a, b, op);
    @(negedge clk);
    a_in = a; b_in = b; op_sel = op; flag_cap = 1;
    #1 chk({req_of(op), " R9 result"}, result, exp_res(a, b, op));
    @(negedge clk);
    flag_cap = 0;
    chk({req_of(op), " flags"}, {1'b0, cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q}, {1'b0, ef});
    chk("R7 compare", {5'd0, eq_q, agt_q, bgt_q}, {5'd0, ef[3:1]});
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [6:0] held;
    void'($urandom(32'd1234));
    #1 chk("R8 reset flags", {1'b0, cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q}, 8'd0);
    #20 rst_n = 1;

    run_op(8'hFF, 8'h01, 3'd0);   // R1 wrap with carry
    run_op(8'h10, 8'h20, 3'd0);   // R1 no carry
    run_op(8'h05, 8'h05, 3'd1);   // R2 equal, no borrow
    run_op(8'h03, 8'h09, 3'd1);   // R2 borrow
    run_op(8'hFF, 8'h37, 3'd3);   // R3 wrap
    run_op(8'h41, 8'h00, 3'd3);   // R3
    run_op(8'h41, 8'hC3, 3'd3);   // R3 B ignored
    run_op(8'h01, 8'h00, 3'd2);   // R5 overflow
    run_op(8'h00, 8'h00, 3'd2);   // R4 zero input
    run_op(8'hFF, 8'h80, 3'd2);   // R4 underflow
    run_op(8'hF0, 8'h3C, 3'd4);   // R6 clears shift flags, R5
    run_op(8'hF0, 8'h3C, 3'd5);
    run_op(8'hF0, 8'h3C, 3'd6);
    run_op(8'hF0, 8'h3C, 3'd7);

    // R8 hold with strobe low
    held = {cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q};
    @(negedge clk);
    a_in = 8'hFF; b_in = 8'h01; op_sel = 3'd0; flag_cap = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 hold", {1'b0, cy_q, shu_q, sho_q, eq_q, agt_q, bgt_q, ne_q}, {1'b0, held});

    for (int i = 0; i < 400; i++)
      run_op(8'($urandom), 8'($urandom), 3'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule